// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block turns several reset causes into one clean, stretched reset for a processor subsystem. It watches three sources: an undervoltage flag produced by an external supply comparator, an active-low push-button input that idles high, and a single-cycle expiry pulse from a watchdog timer. Whenever any source is active, the reset is driven. Once the last active source lets go, the reset is held for a fixed number of clock cycles and then released.

The push-button input is asynchronous. It passes through a synchronizer and then through a sampled filter that accepts a low level only after a set number of consecutive low samples. Shorter dips are dropped. The reset is presented on two flops in opposite polarities. A one-cycle marker flags the cycle in which reset first reads released, so that a host can time the stretch exactly.

All timing is set in clock cycles. `STRETCH_CYC` is the hold time. `MR_QUAL_CYC` is the push-button qualification length. `SYNC_STAGES` is the synchronizer depth. The system reset (`rst_n`) counts as a reset source of its own.

Top module: `sys_reset_stretcher`

## Requirements
- R1: While `rst_n` is low, `rst_o` is 1 and `rst_n_o` is 0. After `rst_n` rises, reset stays asserted and first reads released exactly `STRETCH_CYC` clock edges after the last edge that sampled `rst_n` low.
- R2: A high `uv_i` sampled on an edge makes `rst_o` read 1 after that edge. Reset stays asserted for as long as `uv_i` stays high.
- R3: Reset deasserts exactly `STRETCH_CYC` edges after the last edge on which any source was sampled active, and not earlier.
- R4: A run of at least `MR_QUAL_CYC` consecutive low samples of `mr_n_i` asserts reset. It becomes visible `SYNC_STAGES + MR_QUAL_CYC` edges after the first low sample. The push-button source stays active until `SYNC_STAGES` edges after the first high sample.
- R5: A run of fewer than `MR_QUAL_CYC` consecutive low samples of `mr_n_i` has no effect on either reset output. An `mr_n_i` held high never causes a reset.
- R6: A one-cycle `wd_expire_i` pulse on an idle block produces a reset exactly `STRETCH_CYC` cycles long.
- R7: `rst_n_o` is always the complement of `rst_o`. The two come from separate flops.
- R8: `rst_release_o` is high for exactly one cycle: the first cycle in which `rst_o` reads 0 after being 1. It is low at all other times.
- R9: A source that becomes active while the stretch is running restarts the full `STRETCH_CYC` hold, measured from that source's release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low system reset; also a reset source |
| uv_i | input | 1 | Undervoltage flag, high while supply is low (synchronous to clk) |
| mr_n_i | input | 1 | Asynchronous active-low push-button reset, idles high |
| wd_expire_i | input | 1 | Watchdog expiry pulse, active high |
| rst_o | output | 1 | Stretched reset, active high |
| rst_n_o | output | 1 | Stretched reset, active low |
| rst_release_o | output | 1 | One-cycle marker in the first released cycle |

## Verification
The hardest situation to reach from the ports is the push-button qualification edge. A run of `MR_QUAL_CYC - 1` low samples must vanish without trace, while a run of exactly `MR_QUAL_CYC` samples must yield a full stretch. Because of the synchronizer delay, the outcome only shows several cycles after the input has already returned high. Directed runs of both lengths are applied to an idle block, and the high cycles that follow are counted. Random phases then draw push-button runs centred on the threshold, mixed with undervoltage bursts and watchdog pulses, so that sources overlap inside running stretches. A cycle-level bench model derived from the requirements tracks every edge of these phases.

// File: rtl/rst_stretch_pkg.sv
// Package: shared source bundle and a width helper for the reset stretcher.
package rst_stretch_pkg;

    // One bit per reset cause after qualification.
    typedef struct packed {
        logic undervolt;
        logic manual;
        logic watchdog;
    } rst_src_t;

    // Bits needed to hold values 0..max_val (at least one bit).
    function automatic int unsigned cnt_width(input int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/mr_input_filter.sv
// Module: mr_input_filter
// Synchronizes the asynchronous active-low push-button input and qualifies it.
// A low level is accepted only after QUAL_CYC consecutive low samples at the
// synchronizer output. One high sample drops it again at once.
// Assumes: the input idles high; the synchronizer flops reset to the idle level.
module mr_input_filter #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned QUAL_CYC    = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mr_n_async,
    output logic mr_active_o
);
    import rst_stretch_pkg::*;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   mr_n_sync;

    // Shift the raw pin through the synchronizer chain, idle level on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            for (int i = SYNC_STAGES - 1; i > 0; i--) begin
                sync_q[i] <= sync_q[i-1];
            end
            sync_q[0] <= mr_n_async;
        end
    end

    assign mr_n_sync = sync_q[SYNC_STAGES-1];

    generate
        if (QUAL_CYC == 0) begin : g_no_filter
            // No qualification: the synchronized low is taken directly.
            assign mr_active_o = ~mr_n_sync;
        end else begin : g_run_filter
            localparam int unsigned QW = cnt_width(QUAL_CYC);
            localparam logic [QW-1:0] QMAX = QW'(QUAL_CYC);
            logic [QW-1:0] low_run_q;

            // Count consecutive low samples, saturating at the threshold.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    low_run_q <= '0;
                end else if (mr_n_sync) begin
                    low_run_q <= '0;
                end else if (low_run_q != QMAX) begin
                    low_run_q <= low_run_q + QW'(1);
                end
            end

            assign mr_active_o = (low_run_q == QMAX);
        end
    endgenerate

endmodule

// File: rtl/hold_timer.sv
// Module: hold_timer
// Reloads a down-counter on every cycle in which any source is active. The
// reset request is held while sources are active and for STRETCH_CYC edges
// after the last one. The system reset loads the counter, so power-up behaves
// like a source released on the final reset edge.
// Assumes: STRETCH_CYC >= 1; all sources are synchronous to clk.
module hold_timer #(
    parameter int unsigned STRETCH_CYC = 40_000_000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  rst_stretch_pkg::rst_src_t src_i,
    output logic                      assert_nxt_o
);
    import rst_stretch_pkg::*;

    localparam int unsigned CW = cnt_width(STRETCH_CYC);
    localparam logic [CW-1:0] LOAD = CW'(STRETCH_CYC);

    logic [CW-1:0] left_q;
    logic          any_src;

    // Merge all qualified causes.
    assign any_src = src_i.undervolt | src_i.manual | src_i.watchdog;

    // Next reset level: held by a source or by remaining stretch.
    always_comb begin
        assert_nxt_o = any_src || (left_q > CW'(1));
    end

    // Reload on any source, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= LOAD;
        end else if (any_src) begin
            left_q <= LOAD;
        end else if (left_q != '0) begin
            left_q <= left_q - CW'(1);
        end
    end

endmodule

// File: rtl/reset_out_stage.sv
// Module: reset_out_stage
// Registers the reset request into two flops of opposite polarity, plus a
// one-cycle marker for the first released cycle.
// Assumes: both outputs must show reset while the system reset is held.
module reset_out_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic assert_nxt_i,
    output logic rst_o,
    output logic rst_n_o,
    output logic release_o
);
    logic rst_q;
    logic rst_nq;
    logic rel_q;

    // Separate flops per polarity; the marker fires on the 1-to-0 step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_q  <= 1'b1;
            rst_nq <= 1'b0;
            rel_q  <= 1'b0;
        end else begin
            rst_q  <= assert_nxt_i;
            rst_nq <= ~assert_nxt_i;
            rel_q  <= rst_q & ~assert_nxt_i;
        end
    end

    assign rst_o     = rst_q;
    assign rst_n_o   = rst_nq;
    assign release_o = rel_q;

endmodule

// File: rtl/sys_reset_stretcher.sv
// Module: sys_reset_stretcher (top)
// Combines undervoltage, a filtered push-button and watchdog expiry into one
// reset that is stretched by STRETCH_CYC cycles after the last source lets go.
// Assumes: uv_i and wd_expire_i are synchronous to clk; mr_n_i is asynchronous.
module sys_reset_stretcher #(
    parameter int unsigned STRETCH_CYC = 40_000_000,
    parameter int unsigned MR_QUAL_CYC = 200,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic uv_i,
    input  logic mr_n_i,
    input  logic wd_expire_i,
    output logic rst_o,
    output logic rst_n_o,
    output logic rst_release_o
);
    import rst_stretch_pkg::*;

    logic     mr_active;
    logic     assert_nxt;
    rst_src_t src;

    mr_input_filter #(
        .SYNC_STAGES (SYNC_STAGES),
        .QUAL_CYC    (MR_QUAL_CYC)
    ) mr_filt_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .mr_n_async  (mr_n_i),
        .mr_active_o (mr_active)
    );

    // Bundle the qualified causes for the timer.
    always_comb begin
        src.undervolt = uv_i;
        src.manual    = mr_active;
        src.watchdog  = wd_expire_i;
    end

    hold_timer #(
        .STRETCH_CYC (STRETCH_CYC)
    ) hold_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .src_i        (src),
        .assert_nxt_o (assert_nxt)
    );

    reset_out_stage out_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .assert_nxt_i (assert_nxt),
        .rst_o        (rst_o),
        .rst_n_o      (rst_n_o),
        .release_o    (rst_release_o)
    );

endmodule

// File: rtl/reset_stretcher_chk.sv
// Module: reset_stretcher_chk
// Port-level properties of the reset stretcher, attached by bind.
module reset_stretcher_chk (
    input logic clk,
    input logic rst_n,
    input logic uv_i,
    input logic wd_expire_i,
    input logic rst_o,
    input logic rst_n_o,
    input logic rst_release_o
);
    // R2
    uv_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uv_i |=> rst_o);

    // R6
    wd_trips_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_expire_i |=> rst_o);

    // R7
    polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n_o != rst_o);

    // R8
    release_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_release_o |-> (!rst_o && $past(rst_o)));

    // R8
    release_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_release_o |=> !rst_release_o);

    // R3
    quiet_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_o) |-> $past(!uv_i && !wd_expire_i));

endmodule

bind sys_reset_stretcher reset_stretcher_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .uv_i          (uv_i),
    .wd_expire_i   (wd_expire_i),
    .rst_o         (rst_o),
    .rst_n_o       (rst_n_o),
    .rst_release_o (rst_release_o)
);

// File: tb/sys_reset_stretcher_tb.sv
`timescale 1ns/1ps
module sys_reset_stretcher_tb_top;
    localparam int S = 24;
    localparam int Q = 6;
    localparam int N = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic uv_i = 1'b0;
    logic mr_n_i = 1'b1;
    logic wd_expire_i = 1'b0;
    logic rst_o, rst_n_o, rst_release_o;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sys_reset_stretcher #(
        .STRETCH_CYC (S),
        .MR_QUAL_CYC (Q),
        .SYNC_STAGES (N)
    ) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .uv_i          (uv_i),
        .mr_n_i        (mr_n_i),
        .wd_expire_i   (wd_expire_i),
        .rst_o         (rst_o),
        .rst_n_o       (rst_n_o),
        .rst_release_o (rst_release_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Cycle model built from the requirements (R3, R4, R8 timing).
    logic hist [0:N-1];
    int   run, left;
    logic exp_rst, exp_rel, model_ok = 1'b0;
    logic m_act, m_src, m_nxt;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) hist[i] = 1'b1;
            run = 0; left = S; exp_rst = 1'b1; exp_rel = 1'b0; model_ok = 1'b1;
        end else begin
            m_act = (run >= Q);
            run = hist[N-1] ? 0 : ((run < Q) ? run + 1 : run);
            for (int i = N - 1; i > 0; i--) hist[i] = hist[i-1];
            hist[0] = mr_n_i;
            m_src = uv_i | wd_expire_i | m_act;
            m_nxt = m_src || (left > 1);
            exp_rel = exp_rst && !m_nxt;
            exp_rst = m_nxt;
            left = m_src ? S : ((left > 0) ? left - 1 : 0);
        end
    end

    // Compare every cycle against the model, away from the clock edge.
    always @(negedge clk) begin
        if (model_ok && !done) begin
            chk("R3 model rst_o", int'(rst_o), int'(exp_rst));
            chk("R7 model rst_n_o", int'(rst_n_o), int'(!exp_rst));
            chk("R8 model release", int'(rst_release_o), int'(exp_rel));
        end
    end

    task automatic wait_fall(output int n);
        n = 0;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            n++;
            if (!rst_o) break;
        end
    endtask

    task automatic count_high(input int win, output int hi);
        hi = 0;
        for (int i = 0; i < win; i++) begin
            @(negedge clk);
            if (rst_o) hi++;
        end
    endtask

    task automatic settle();
        int n;
        wait_fall(n);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        int n, hi;
        int uv_left, mr_left;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        // R1: reset state
        chk("R1 reset rst_o", int'(rst_o), 1);
        chk("R1 reset rst_n_o", int'(rst_n_o), 0);
        rst_n = 1'b1;
        wait_fall(n);
        chk("R1 power-on stretch", n, S);
        chk("R8 power-on release", int'(rst_release_o), 1);
        repeat (4) @(negedge clk);

        // R6: single watchdog pulse
        wd_expire_i = 1'b1;
        @(negedge clk); wd_expire_i = 1'b0;
        chk("R6 wd asserted", int'(rst_o), 1);
        wait_fall(n);
        chk("R6 wd stretch", n, S);
        chk("R8 wd release", int'(rst_release_o), 1);
        repeat (4) @(negedge clk);

        // R2: long undervoltage, then stretch from release
        uv_i = 1'b1;
        count_high(3 * S, hi);
        chk("R2 uv held", hi, 3 * S);
        uv_i = 1'b0;
        wait_fall(n);
        chk("R3 uv stretch", n, S);
        repeat (4) @(negedge clk);

        // R9: restart inside a running stretch
        wd_expire_i = 1'b1;
        @(negedge clk); wd_expire_i = 1'b0;
        repeat (10) @(negedge clk);
        uv_i = 1'b1;
        @(negedge clk); uv_i = 1'b0;
        wait_fall(n);
        chk("R9 restart stretch", n, S);
        repeat (4) @(negedge clk);

        // R5: run one sample short of qualification
        mr_n_i = 1'b0;
        repeat (Q - 1) @(negedge clk);
        mr_n_i = 1'b1;
        count_high(Q + N + 8, hi);
        chk("R5 short run ignored", hi, 0);

        // R4: run of exactly Q samples gives a full stretch
        mr_n_i = 1'b0;
        repeat (Q) @(negedge clk);
        mr_n_i = 1'b1;
        count_high(Q + N + S + 10, hi);
        chk("R4 exact run stretch", hi, S);
        repeat (4) @(negedge clk);

        // R4: long hold, assertion latency and release timing
        mr_n_i = 1'b0;
        n = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            n++;
            if (rst_o) break;
        end
        chk("R4 mr assert latency", n, N + Q + 1);
        repeat (4) @(negedge clk);
        mr_n_i = 1'b1;
        wait_fall(n);
        chk("R4 mr release timing", n, N + S + 1);
        chk("R8 mr release", int'(rst_release_o), 1);
        repeat (4) @(negedge clk);

        // Random mix, checked by the cycle model (R3, R4, R5, R9)
        uv_left = 0; mr_left = 0;
        for (int c = 0; c < 6000; c++) begin
            @(negedge clk);
            if (uv_left > 0) uv_left--;
            else if ($urandom_range(0, 199) == 0) uv_left = $urandom_range(1, 10);
            uv_i = (uv_left > 0);
            wd_expire_i = ($urandom_range(0, 149) == 0);
            if (mr_left > 0) mr_left--;
            else if ($urandom_range(0, 59) == 0) mr_left = $urandom_range(Q - 2, Q + 3);
            mr_n_i = !(mr_left > 0);
        end
        uv_i = 1'b0; wd_expire_i = 1'b0; mr_n_i = 1'b1;
        settle();
        chk("R3 idle after random", int'(rst_o), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        done = 1'b1;
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule